// File: doc/BRIEF.md
# ADC Serial Command Decoder

This block sits behind the serial shifter of a multichannel successive-approximation converter. It takes one already-assembled 8-bit command byte per `cmd_valid` cycle and sorts it into one of three kinds: conversion start, channel configuration, or mode control. The kind is chosen from the low nibble, and only for bytes whose top bit (the start bit) is 1. It keeps one record per channel, for all eight channels. A record holds an input-mode flag (differential or single-ended) and a 3-bit range code. It also keeps one global operating-mode register.

An accepted conversion start produces a one-cycle `conv_start` pulse. The pulse comes with a snapshot of the channel number and that channel's stored record, and the snapshot holds until the next accepted start. Mode bytes move the block between its clocking modes and two power-down levels. One mode code performs a soft reset of every register. Full power-down can only be left by way of partial power-down, so a stray byte cannot wake the converter.

Top module: `adc_cmd_decoder`

## Requirements
- R1: After `rst_n` is released, the outputs are as follows. `op_mode` is 000 (external clock), `pwr_down` is 0 and `conv_start` is 0. `conv_chan` is 0, `conv_diff` is 0 and `conv_rng` is 111. Every channel record is single-ended (flag 0) with range code 111, the widest bipolar range.
- R2: A byte with bit 7 = 0, or any byte presented while `cmd_valid` is 0, changes no state and raises no `conv_start`.
- R3: A start-bit byte whose bits 3:0 are 0000 is a conversion start on channel bits 6:4. One cycle later `conv_start` is 1. In that same cycle `conv_chan`, `conv_diff` and `conv_rng` show the channel and its stored flag and range.
- R4: A start-bit byte whose bits 3:0 are neither 0000 nor 1000 is a configuration write for channel bits 6:4. It stores bit 3 as the flag (1 = differential) and bits 2:0 as the range code. It is accepted in every mode, and a conversion start in the very next cycle already sees the new record. A configuration with nibble 0000 is therefore treated as a start.
- R5: A start-bit byte whose bits 3:0 are 1000 is a mode byte with code bits 6:4. Codes 000 (external clock), 001 (external acquisition), 010 (internal clock), 110 (partial power-down) and 111 (full power-down) load `op_mode` one cycle later. `pwr_down` is 1 exactly when `op_mode` is 110 or 111.
- R6: Mode codes 011 and 101 are reserved and change no state.
- R7: Mode code 100 is a soft reset. One cycle later every channel record is back at its R1 value and `op_mode` is 000, never 100. The conversion snapshot outputs keep their values.
- R8: While `op_mode` is 110 or 111, conversion-start bytes are ignored. `conv_start` stays 0 and the snapshot outputs hold.
- R9: While `op_mode` is 111, the only mode byte with an effect is code 110. All other mode codes, soft reset included, are ignored.
- R10: `conv_start` is high for exactly one cycle for each accepted start. The snapshot outputs change only in a cycle where `conv_start` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A command byte is presented this cycle |
| cmd_byte | input | 8 | Assembled command byte |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Channel of the latest accepted start |
| conv_diff | output | 1 | Input-mode flag captured with that start (1 = differential) |
| conv_rng | output | 3 | Range code captured with that start |
| op_mode | output | 3 | Current operating mode code |
| pwr_down | output | 1 | 1 in partial or full power-down |

## Verification
Two functions can overlap in one cycle: a conversion start being reported and a configuration write to the same channel. The bench provokes this in two ways. First, it sends a start byte followed at once by a configuration byte for the same channel. During the pulse cycle the snapshot must keep the old record, and a later start must show the new one. Second, it sends a configuration write immediately followed by a start on that channel, which must already carry the newly written record. A behavioural model of the channel records and mode judges every cycle of these sequences, and of a long pseudo-random byte stream that reaches the power-down states.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
    localparam int FIELD_W = 3;
    localparam int RNG_W   = 3;
    localparam int BYTE_W  = 8;

    typedef enum logic [FIELD_W-1:0] {
        MD_EXT_CLK  = 3'b000,
        MD_EXT_ACQ  = 3'b001,
        MD_INT_CLK  = 3'b010,
        MD_RSV_A    = 3'b011,
        MD_SOFT_RST = 3'b100,
        MD_RSV_B    = 3'b101,
        MD_PART_PD  = 3'b110,
        MD_FULL_PD  = 3'b111
    } mode_e;

    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_START = 2'd1,
        K_CFG   = 2'd2,
        K_MODE  = 2'd3
    } kind_e;

    typedef struct packed {
        logic             diff;
        logic [RNG_W-1:0] rng;
    } chcfg_t;
endpackage

// File: rtl/adc_cmd_classify.sv
module adc_cmd_classify
    import adc_cmd_pkg::*;
(
    input  logic                cmd_valid,
    input  logic [BYTE_W-1:0]   cmd_byte,
    output kind_e               kind,
    output logic [FIELD_W-1:0]  field,
    output chcfg_t              cfg
);
    localparam int NIB_W = BYTE_W - 1 - FIELD_W;

    logic [NIB_W-1:0] nib;

    always_comb begin
        nib       = cmd_byte[NIB_W-1:0];
        field     = cmd_byte[BYTE_W-2 -: FIELD_W];
        cfg.diff  = nib[NIB_W-1];
        cfg.rng   = nib[RNG_W-1:0];
        kind      = K_NONE;
        if (cmd_valid && cmd_byte[BYTE_W-1]) begin
            // an all-zero nibble wins over a configuration reading of the byte
            if (nib == '0)
                kind = K_START;
            else if (nib == {1'b1, {(NIB_W-1){1'b0}}})
                kind = K_MODE;
            else
                kind = K_CFG;
        end
    end
endmodule

// File: rtl/adc_cmd_mode_ctl.sv
module adc_cmd_mode_ctl
    import adc_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  kind_e              kind,
    input  logic [FIELD_W-1:0] field,
    output mode_e              mode,
    output logic               soft_rst,
    output logic               pd
);
    typedef struct packed {
        mode_e mode;
    } mstate_t;

    mstate_t st_d, st_q;
    mode_e   req;

    always_comb begin
        st_d     = st_q;
        soft_rst = 1'b0;
        req      = mode_e'(field);
        if (kind == K_MODE) begin
            if (st_q.mode == MD_FULL_PD) begin
                // wake only through partial power-down
                if (req == MD_PART_PD)
                    st_d.mode = MD_PART_PD;
            end else begin
                unique case (req)
                    MD_RSV_A, MD_RSV_B: st_d = st_q;
                    MD_SOFT_RST: begin
                        st_d.mode = MD_EXT_CLK;
                        soft_rst  = 1'b1;
                    end
                    default: st_d.mode = req;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{mode: MD_EXT_CLK};
        else
            st_q <= st_d;
    end

    assign mode = st_q.mode;
    assign pd   = (st_q.mode == MD_PART_PD) || (st_q.mode == MD_FULL_PD);
endmodule

// File: rtl/adc_cmd_cfgfile.sv
module adc_cmd_cfgfile
    import adc_cmd_pkg::*;
#(
    parameter int               CH_W    = FIELD_W,
    parameter logic [RNG_W-1:0] DEF_RNG = 3'b111
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_chan,
    input  chcfg_t          wr_cfg,
    input  logic [CH_W-1:0] rd_chan,
    output chcfg_t          rd_cfg
);
    localparam int     NCH     = 1 << CH_W;
    localparam chcfg_t DEF_CFG = '{diff: 1'b0, rng: DEF_RNG};

    chcfg_t rec_q [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chcfg_t rec_d, rec_r;

        always_comb begin
            rec_d = rec_r;
            if (clr)
                rec_d = DEF_CFG;
            else if (wr_en && (wr_chan == CH_W'(i)))
                rec_d = wr_cfg;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rec_r <= DEF_CFG;
            else
                rec_r <= rec_d;
        end

        assign rec_q[i] = rec_r;
    end

    assign rd_cfg = rec_q[rd_chan];
endmodule

// File: rtl/adc_cmd_decoder.sv
module adc_cmd_decoder
    import adc_cmd_pkg::*;
#(
    parameter logic [RNG_W-1:0] DEF_RNG = 3'b111
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [7:0]         cmd_byte,
    output logic               conv_start,
    output logic [2:0]         conv_chan,
    output logic               conv_diff,
    output logic [2:0]         conv_rng,
    output logic [2:0]         op_mode,
    output logic               pwr_down
);
    localparam int CH_W = FIELD_W;

    typedef struct packed {
        logic            start;
        logic [CH_W-1:0] chan;
        chcfg_t          cfg;
    } snap_t;

    kind_e              kind;
    logic [FIELD_W-1:0] field;
    chcfg_t             byte_cfg;
    chcfg_t             sel_cfg;
    mode_e              mode;
    logic               soft_rst;
    logic               pd;
    snap_t              snap_d, snap_q;

    adc_cmd_classify u_cls (
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .kind      (kind),
        .field     (field),
        .cfg       (byte_cfg)
    );

    adc_cmd_mode_ctl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .field    (field),
        .mode     (mode),
        .soft_rst (soft_rst),
        .pd       (pd)
    );

    adc_cmd_cfgfile #(.CH_W(CH_W), .DEF_RNG(DEF_RNG)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_rst),
        .wr_en   (kind == K_CFG),
        .wr_chan (field),
        .wr_cfg  (byte_cfg),
        .rd_chan (field),
        .rd_cfg  (sel_cfg)
    );

    always_comb begin
        snap_d       = snap_q;
        snap_d.start = 1'b0;
        if (kind == K_START && !pd) begin
            snap_d.start = 1'b1;
            snap_d.chan  = field;
            snap_d.cfg   = sel_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            snap_q <= '{start: 1'b0, chan: '0, cfg: '{diff: 1'b0, rng: DEF_RNG}};
        else
            snap_q <= snap_d;
    end

    assign conv_start = snap_q.start;
    assign conv_chan  = snap_q.chan;
    assign conv_diff  = snap_q.cfg.diff;
    assign conv_rng   = snap_q.cfg.rng;
    assign op_mode    = mode;
    assign pwr_down   = pd;
endmodule

// File: rtl/adc_cmd_decoder_chk.sv
module adc_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_byte,
    input logic       conv_start,
    input logic [2:0] conv_chan,
    input logic [2:0] conv_rng,
    input logic [2:0] op_mode,
    input logic       pwr_down
);
    AST_START_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($past(cmd_valid) && $past(cmd_byte[7]) && ($past(cmd_byte[3:0]) == 4'h0))); // R3

    AST_NO_START_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($past(op_mode) != 3'b110 && $past(op_mode) != 3'b111)); // R8

    AST_FULL_PD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'b111) |=> (op_mode == 3'b111 || op_mode == 3'b110)); // R9

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode != 3'b011 && op_mode != 3'b101 && op_mode != 3'b100)); // R6

    AST_SNAP_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(conv_chan) || !$stable(conv_rng)) |-> conv_start); // R10

    AST_NOSTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_byte[7]) |=> ($stable(op_mode) && !conv_start)); // R2

    AST_PD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down) |-> (op_mode == 3'b110 || op_mode == 3'b111)); // R5
endmodule

bind adc_cmd_decoder adc_cmd_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (cmd_byte),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .conv_rng   (conv_rng),
    .op_mode    (op_mode),
    .pwr_down   (pwr_down)
);

// File: tb/adc_cmd_decoder_bench.sv
`timescale 1ns/1ps
module adc_cmd_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       conv_start;
    logic [2:0] conv_chan;
    logic       conv_diff;
    logic [2:0] conv_rng;
    logic [2:0] op_mode;
    logic       pwr_down;

    int errors = 0;
    int checks = 0;

    // behavioural reference state
    logic       m_diff [8];
    logic [2:0] m_rng  [8];
    int         m_mode;
    logic       m_start;
    int         m_chan;
    logic       m_cdiff;
    logic [2:0] m_crng;

    always #2.5 clk = ~clk;

    adc_cmd_decoder u_adc_cmd_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .conv_diff  (conv_diff),
        .conv_rng   (conv_rng),
        .op_mode    (op_mode),
        .pwr_down   (pwr_down)
    );

    task automatic model_defaults();
        for (int i = 0; i < 8; i++) begin
            m_diff[i] = 1'b0;
            m_rng[i]  = 3'b111;
        end
        m_mode = 0;
    endtask

    task automatic model_step(input logic v, input logic [7:0] b);
        int f;
        f = int'(b[6:4]);
        m_start = 1'b0;
        if (v && b[7]) begin
            if (b[3:0] == 4'h0) begin
                if (m_mode != 6 && m_mode != 7) begin
                    m_start = 1'b1;
                    m_chan  = f;
                    m_cdiff = m_diff[f];
                    m_crng  = m_rng[f];
                end
            end else if (b[3:0] == 4'h8) begin
                if (m_mode == 7) begin
                    if (f == 6) m_mode = 6;
                end else if (f == 4) begin
                    model_defaults();
                end else if (f != 3 && f != 5) begin
                    m_mode = f;
                end
            end else begin
                m_diff[f] = b[3];
                m_rng[f]  = b[2:0];
            end
        end
    endtask

    task automatic compare(input string tag);
        logic ok;
        logic exp_pd;
        exp_pd = (m_mode == 6 || m_mode == 7);
        ok = (conv_start === m_start) && (conv_chan === 3'(m_chan)) &&
             (conv_diff === m_cdiff) && (conv_rng === m_crng) &&
             (op_mode === 3'(m_mode)) && (pwr_down === exp_pd);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got start=%0b chan=%0d diff=%0b rng=%0d mode=%0d pd=%0b, expected start=%0b chan=%0d diff=%0b rng=%0d mode=%0d pd=%0b",
                     tag, conv_start, conv_chan, conv_diff, conv_rng, op_mode, pwr_down,
                     m_start, m_chan, m_cdiff, m_crng, m_mode, exp_pd);
        end
    endtask

    // called at a falling edge: drive, let one rising edge pass, compare at the next falling edge
    task automatic step(input logic v, input logic [7:0] b, input string tag);
        cmd_valid = v;
        cmd_byte  = b;
        @(posedge clk);
        model_step(v, b);
        @(negedge clk);
        cmd_valid = 1'b0;
        compare(tag);
    endtask

    task automatic send(input logic [7:0] b, input string tag);
        step(1'b1, b, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 8'h00, tag);
    endtask

    initial begin : watchdog
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: got no completion, expected end of sequence");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [15:0] lfsr;
        model_defaults();
        m_start = 1'b0;
        m_chan  = 0;
        m_cdiff = 1'b0;
        m_crng  = 3'b111;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 reset state");

        // R2: no start bit, and bytes without valid
        send(8'h70, "R2 no start bit");
        send(8'h08, "R2 no start bit mode-like");
        step(1'b0, 8'h90, "R2 invalid strobe");
        idle("R2 idle");

        // R3: start on channel 3 with defaults
        send(8'hB0, "R3 start ch3 defaults");
        idle("R10 pulse ends");

        // R4: config write then start next cycle
        send(8'hB5, "R4 cfg ch3 se rng5");
        send(8'hB0, "R4 start sees new cfg");
        send(8'hDA, "R4 cfg ch5 diff rng2");
        send(8'hD0, "R3 start ch5");
        send(8'hD0, "R10 back-to-back start");

        // R10: start then config of same channel in pulse cycle
        send(8'hB0, "R10 start ch3");
        send(8'hB3, "R10 cfg during pulse");
        idle("R10 snapshot holds");
        send(8'hB0, "R10 later start sees update");

        // R5 / R6 mode bytes
        send(8'h98, "R5 ext acquisition");
        send(8'hA8, "R5 internal clock");
        send(8'hB8, "R6 reserved 011");
        send(8'hD8, "R6 reserved 101");
        send(8'h88, "R5 ext clock");

        // R8: partial power-down
        send(8'hE8, "R5 partial pd");
        send(8'h90, "R8 start ignored partial pd");
        send(8'h9C, "R4 cfg in partial pd");
        idle("R8 idle partial pd");

        // R9: full power-down exit sequence
        send(8'hF8, "R5 full pd");
        send(8'hB0, "R8 start ignored full pd");
        send(8'h88, "R9 ext clock ignored");
        send(8'hC8, "R9 soft reset ignored");
        send(8'h98, "R9 acquisition ignored");
        send(8'hE8, "R9 partial accepted");
        send(8'h88, "R9 ext clock after partial");
        send(8'h90, "R4 start sees pd cfg");

        // R7: soft reset
        send(8'hA8, "R5 internal clock");
        send(8'hC8, "R7 soft reset");
        send(8'h90, "R7 ch1 default");
        send(8'hD0, "R7 ch5 default");

        // random stream through the model
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[9] | lfsr[2], {lfsr[0] | lfsr[5], lfsr[8:6], lfsr[4:1] & {lfsr[11], 3'b111}},
                 "R10 random stream");
            if (n % 97 == 96) send(8'hE8, "R9 random wake");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule